// File: doc/BRIEF.md
# Stereo Stream Intercept and Substitution Controller

This block sits behind a framed serial port and decides, for each of five stereo sample streams, whether the sample pair that reaches the stream's consumer is the stream's own (native) pair or a pair supplied by the serial-port host. Each stream has an intercept enable. While it is clear, the host can only watch the stream: every native pair is forwarded unchanged. While it is set, each sample tick of the stream raises a request bit that the host reads in the status word of the next frame. If the host answers in the following frame with a control word that flags that stream valid, the host's pair replaces the native one. Otherwise the native pair is forwarded.

Every captured sample takes the same path whatever the mode. It is captured in the frame of its tick, reported as requested during the next frame, and judged against the control word of the frame after that. It is then released as a one-cycle strobe in the cycle after the third frame boundary that follows the tick. Enable changes are sampled only at frame boundaries. A stream whose rate equals the frame rate reports its request and output-valid status bits as permanently set. Slot serialisation and the generation of frame and rate ticks are handled elsewhere.

Top module: `intercept_sub_ctrl`

## Requirements
- R1: While reset is held, and until the first frame boundary after it, `out_stb`, `out_sub`, `out_smp`, and the registered parts of `stat_req` and `stat_ovld`, are all zero. With `full_rate` low the status outputs are therefore zero.
- R2: `icpt_en` is sampled only in the cycle in which `frame_start` is high, and that value governs the whole frame that starts there. Changes of `icpt_en` in other cycles have no effect.
- R3: A stream whose intercept is disabled forwards its native pair unchanged, whatever the control words carry.
- R4: Every `rate_tick[c]` captures that stream's native pair and yields exactly one `out_stb[c]` pulse. The pulse appears in the cycle after the third `frame_start` that follows the tick. A tick in a `frame_start` cycle belongs to the frame that begins there. `out_smp` changes only together with a strobe.
- R5: `stat_req[c]` is high for the whole frame that follows a frame in which stream c ticked while its intercept was enabled. It changes only in the cycle after `frame_start`, or when `full_rate` changes.
- R6: When stream c's intercept is enabled in the frame where a pair is judged, the pair was requested in the frame before, and the last control word of that frame has `ctl_vld[c]` set, then the released pair is that control word's pair for c, and `out_sub[c]` is high with the strobe.
- R7: When the valid flag is clear, or the frame had no control word, the host's pair is discarded. The native pair is released with `out_sub[c]` low.
- R8: A valid flag is ignored for a sample that ticked while its intercept was disabled, even if the intercept is enabled when the sample is judged.
- R9: While `full_rate[c]` is high, `stat_req[c]` and `stat_ovld[c]` read 1.
- R10: `stat_ovld[c]` is high for the whole frame at whose start a pair of stream c was released. Every `out_stb[c]` pulse falls in such a frame.
- R11: A control word whose `ctl_stb` coincides with `frame_start` belongs to the new frame. Within one frame, the last control word replaces earlier ones.
- R12: Stream bit c in every vector is ordered as serial port 0 (bit 0), serial port 1, synthesizer, playback, capture (bit 4). Each stream's pair occupies bits [c*2*DW +: 2*DW] of the pair buses, with the right sample in the low DW bits and the left sample in the high DW bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_start | input | 1 | One-cycle pulse at the first cycle of each serial frame |
| icpt_en | input | NCH | Intercept enables, sampled at frame boundaries |
| full_rate | input | NCH | Stream rate equals the frame rate |
| rate_tick | input | NCH | One-cycle sample tick per stream, at most one per frame |
| nat_smp | input | NCH*2*DW | Native sample pairs, valid with the stream's tick |
| ctl_stb | input | 1 | Decoded control word present this cycle |
| ctl_vld | input | NCH | Substitution-valid flags from the control word |
| ctl_smp | input | NCH*2*DW | Substitution pairs received from the serial port |
| stat_req | output | NCH | Request bits for the status word |
| stat_ovld | output | NCH | Output-valid bits for the status word |
| out_stb | output | NCH | One-cycle strobe per released pair |
| out_sub | output | NCH | Released pair is the host's pair |
| out_smp | output | NCH*2*DW | Released pairs, held between strobes |

## Verification
On a frame boundary the block releases the oldest captured pair of a stream. On that same edge it also latches the stream's new tick and may latch a control word. Both collide when `rate_tick` or `ctl_stb` is driven in the `frame_start` cycle. The bench forces that collision in dedicated frames and also lands on it at random offsets. It judges the outcome with a frame-numbered queue model: a tick on the boundary must appear in the new frame's numbering, so it is released one frame later than a tick in the cycle before. A boundary control word must steer only the pair judged in the frame that the boundary opens.

// File: rtl/isc_pkg.sv
// Shared constants for the intercept/substitution controller.
// Stream bit order is fixed because the control and status words decode it.
package isc_pkg;
    localparam int ISC_NCH = 5;
    localparam int ISC_DW  = 16;

    // Stream positions inside every per-stream vector.
    typedef enum logic [2:0] {
        STRM_SP0   = 3'd0,
        STRM_SP1   = 3'd1,
        STRM_SYNTH = 3'd2,
        STRM_PLAY  = 3'd3,
        STRM_CAPT  = 3'd4
    } isc_strm_e;
endpackage

// File: rtl/isc_ctlword.sv
// Holds the substitution flags and pairs of the latest control word of the
// current frame. Assumes ctl_stb in a frame_start cycle belongs to the new frame.
module isc_ctlword #(
    parameter int NCH = 5,
    parameter int DW  = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_start,
    input  logic                  ctl_stb,
    input  logic [NCH-1:0]        ctl_vld,
    input  logic [NCH*2*DW-1:0]   ctl_smp,
    output logic [NCH-1:0]        cur_vld,
    output logic [NCH*2*DW-1:0]   cur_smp
);
    // Flags: cleared at each boundary, overwritten by any control word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_vld <= '0;
        end else if (ctl_stb) begin
            cur_vld <= ctl_vld;
        end else if (frame_start) begin
            cur_vld <= '0;
        end
    end

    // Pairs: follow the latest control word; flags decide whether they count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_smp <= '0;
        end else if (ctl_stb) begin
            cur_smp <= ctl_smp;
        end
    end
endmodule

// File: rtl/isc_lane.sv
// One stereo stream: captures a native pair on its tick, carries it through
// the request frame and the response frame, then releases native or host pair.
// Assumes at most one tick per frame; a tick on frame_start opens the new frame.
module isc_lane #(
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_start,
    input  logic            en,
    input  logic            tick,
    input  logic [2*DW-1:0] nat,
    input  logic            host_vld,
    input  logic [2*DW-1:0] host_smp,
    output logic            req_q,
    output logic            ovld_q,
    output logic            stb_q,
    output logic            sub_q,
    output logic [2*DW-1:0] smp_q
);
    localparam int PW = 2 * DW;

    logic          act;
    logic          cap_any;
    logic [PW-1:0] cap_smp;
    logic          rq_any;
    logic [PW-1:0] rq_smp;
    logic          rsp_any;
    logic          rsp_req;
    logic [PW-1:0] rsp_smp;
    logic          honour;

    // Host pair counts only if requested, still intercepting, and flagged valid.
    assign honour = rsp_any & rsp_req & act & host_vld;

    // Intercept state: follows the enable only at frame boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n)           act <= 1'b0;
        else if (frame_start) act <= en;
    end

    // Capture stage: sample ticked in the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_any <= 1'b0;
            cap_smp <= '0;
        end else begin
            if (frame_start)   cap_any <= tick;
            else if (tick)     cap_any <= 1'b1;
            if (tick)          cap_smp <= nat;
        end
    end

    // Request and response stages: advance one step per frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rq_any  <= 1'b0;
            req_q   <= 1'b0;
            rq_smp  <= '0;
            rsp_any <= 1'b0;
            rsp_req <= 1'b0;
            rsp_smp <= '0;
        end else if (frame_start) begin
            rq_any  <= cap_any;
            req_q   <= cap_any & act;
            rq_smp  <= cap_smp;
            rsp_any <= rq_any;
            rsp_req <= req_q;
            rsp_smp <= rq_smp;
        end
    end

    // Release: one strobe per judged sample, status valid for the new frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q  <= 1'b0;
            sub_q  <= 1'b0;
            ovld_q <= 1'b0;
            smp_q  <= '0;
        end else begin
            stb_q <= frame_start & rsp_any;
            sub_q <= frame_start & honour;
            if (frame_start) ovld_q <= rsp_any;
            if (frame_start && rsp_any) smp_q <= honour ? host_smp : rsp_smp;
        end
    end
endmodule

// File: rtl/intercept_sub_ctrl.sv
// Top: one control-word latch shared by NCH stream lanes. Status bits of
// streams running at the frame rate are forced high.
module intercept_sub_ctrl
    import isc_pkg::*;
#(
    parameter int NCH = ISC_NCH,
    parameter int DW  = ISC_DW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_start,
    input  logic [NCH-1:0]        icpt_en,
    input  logic [NCH-1:0]        full_rate,
    input  logic [NCH-1:0]        rate_tick,
    input  logic [NCH*2*DW-1:0]   nat_smp,
    input  logic                  ctl_stb,
    input  logic [NCH-1:0]        ctl_vld,
    input  logic [NCH*2*DW-1:0]   ctl_smp,
    output logic [NCH-1:0]        stat_req,
    output logic [NCH-1:0]        stat_ovld,
    output logic [NCH-1:0]        out_stb,
    output logic [NCH-1:0]        out_sub,
    output logic [NCH*2*DW-1:0]   out_smp
);
    localparam int PW = 2 * DW;

    logic [NCH-1:0]      cur_vld;
    logic [NCH*PW-1:0]   cur_smp;
    logic [NCH-1:0]      req_q;
    logic [NCH-1:0]      ovld_q;

    isc_ctlword #(.NCH(NCH), .DW(DW)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .ctl_stb     (ctl_stb),
        .ctl_vld     (ctl_vld),
        .ctl_smp     (ctl_smp),
        .cur_vld     (cur_vld),
        .cur_smp     (cur_smp)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        isc_lane #(.DW(DW)) u_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .frame_start (frame_start),
            .en          (icpt_en[c]),
            .tick        (rate_tick[c]),
            .nat         (nat_smp[c*PW +: PW]),
            .host_vld    (cur_vld[c]),
            .host_smp    (cur_smp[c*PW +: PW]),
            .req_q       (req_q[c]),
            .ovld_q      (ovld_q[c]),
            .stb_q       (out_stb[c]),
            .sub_q       (out_sub[c]),
            .smp_q       (out_smp[c*PW +: PW])
        );
    end

    // Frame-rate streams always report request and output valid.
    assign stat_req  = req_q  | full_rate;
    assign stat_ovld = ovld_q | full_rate;
endmodule

// File: rtl/isc_chk.sv
// Checker for intercept_sub_ctrl: timing relations between strobes, status
// bits and frame boundaries. Attached by the bind at the end of this file.
module isc_chk #(
    parameter int NCH = 5,
    parameter int DW  = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                frame_start,
    input logic [NCH-1:0]      full_rate,
    input logic [NCH-1:0]      stat_req,
    input logic [NCH-1:0]      stat_ovld,
    input logic [NCH-1:0]      out_stb,
    input logic [NCH-1:0]      out_sub,
    input logic [NCH*2*DW-1:0] out_smp
);
    AST_STB_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (out_stb != '0) |-> $past(frame_start));                        // R4

    AST_SMP_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_stb == '0) |-> $stable(out_smp));                          // R4

    AST_SUB_WITH_STB: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sub != '0) |-> ((out_sub & ~out_stb) == '0));              // R6

    AST_STB_IN_OVLD_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (out_stb != '0) |-> ((out_stb & ~stat_ovld) == '0));           // R10

    AST_REQ_FRAME_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(frame_start) && $stable(full_rate)) |-> $stable(stat_req));  // R5

    AST_OVLD_FRAME_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(frame_start) && $stable(full_rate)) |-> $stable(stat_ovld)); // R10
endmodule

bind intercept_sub_ctrl isc_chk #(.NCH(NCH), .DW(DW)) u_isc_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .full_rate   (full_rate),
    .stat_req    (stat_req),
    .stat_ovld   (stat_ovld),
    .out_stb     (out_stb),
    .out_sub     (out_sub),
    .out_smp     (out_smp)
);

// File: tb/intercept_sub_ctrl_tb.sv
// Bench: frame-numbered queue model of every captured sample, compared with
// the ports on every falling clock edge.
module intercept_sub_ctrl_tb;
    localparam int NCH  = 5;
    localparam int DW   = 16;
    localparam int PW   = 2 * DW;
    localparam int FLEN = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_start = 1'b0;
    logic [NCH-1:0]    icpt_en = '0;
    logic [NCH-1:0]    full_rate = '0;
    logic [NCH-1:0]    rate_tick = '0;
    logic [NCH*PW-1:0] nat_smp = '0;
    logic              ctl_stb = 1'b0;
    logic [NCH-1:0]    ctl_vld = '0;
    logic [NCH*PW-1:0] ctl_smp = '0;
    logic [NCH-1:0]    stat_req, stat_ovld, out_stb, out_sub;
    logic [NCH*PW-1:0] out_smp;

    int n_chk = 0;
    int n_fail = 0;
    int frame_ctr = 0;
    bit done = 0;
    string cur_tag = "init";

    always #10 clk = ~clk;

    intercept_sub_ctrl #(.NCH(NCH), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .icpt_en(icpt_en), .full_rate(full_rate), .rate_tick(rate_tick),
        .nat_smp(nat_smp), .ctl_stb(ctl_stb), .ctl_vld(ctl_vld),
        .ctl_smp(ctl_smp), .stat_req(stat_req), .stat_ovld(stat_ovld),
        .out_stb(out_stb), .out_sub(out_sub), .out_smp(out_smp)
    );

    // Reference model: each tick is stamped with its frame number and the
    // intercept state of that frame; it is judged two frames later.
    int          q_frm [NCH][$];
    logic [31:0] q_nat [NCH][$];
    bit          q_req [NCH][$];
    bit [NCH-1:0] m_act, m_cv, e_stb, e_sub, e_req, e_ovld;
    logic [31:0] m_cd [NCH];
    logic [31:0] e_smp [NCH];
    int m_frame = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                q_frm[c].delete(); q_nat[c].delete(); q_req[c].delete();
                m_cd[c] = '0; e_smp[c] = '0;
            end
            m_act = '0; m_cv = '0; e_stb = '0; e_sub = '0;
            e_req = '0; e_ovld = '0; m_frame = 0;
        end else begin
            e_stb = '0; e_sub = '0;
            if (frame_start) begin
                for (int c = 0; c < NCH; c++) begin
                    e_ovld[c] = 1'b0;
                    e_req[c]  = 1'b0;
                    if (q_frm[c].size() > 0 && q_frm[c][0] == m_frame - 2) begin
                        bit hon;
                        hon = q_req[c][0] && m_act[c] && m_cv[c];
                        e_stb[c] = 1'b1;
                        e_sub[c] = hon;
                        e_smp[c] = hon ? m_cd[c] : q_nat[c][0];
                        e_ovld[c] = 1'b1;
                        void'(q_frm[c].pop_front());
                        void'(q_nat[c].pop_front());
                        void'(q_req[c].pop_front());
                    end
                    for (int i = 0; i < q_frm[c].size(); i++)
                        if (q_frm[c][i] == m_frame && q_req[c][i]) e_req[c] = 1'b1;
                end
                m_act = icpt_en;
                m_cv  = '0;
                m_frame++;
            end
            if (ctl_stb) begin
                m_cv = ctl_vld;
                for (int c = 0; c < NCH; c++) m_cd[c] = ctl_smp[c*PW +: PW];
            end
            for (int c = 0; c < NCH; c++)
                if (rate_tick[c]) begin
                    q_frm[c].push_back(m_frame);
                    q_nat[c].push_back(nat_smp[c*PW +: PW]);
                    q_req[c].push_back(m_act[c]);
                end
        end
    end

    task automatic chk(input bit ok, input string req, input int c,
                       input logic [31:0] act_v, input logic [31:0] exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s [%s] stream %0d: actual %h expected %h",
                     req, cur_tag, c, act_v, exp_v);
        end
    endtask

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int c = 0; c < NCH; c++) begin
                bit er, eo;
                er = e_req[c] | full_rate[c];
                eo = e_ovld[c] | full_rate[c];
                chk(out_stb[c] == e_stb[c], "R4", c, 32'(out_stb[c]), 32'(e_stb[c]));
                chk(out_sub[c] == e_sub[c], "R6", c, 32'(out_sub[c]), 32'(e_sub[c]));
                chk(stat_req[c] == er, full_rate[c] ? "R9" : "R5", c,
                    32'(stat_req[c]), 32'(er));
                chk(stat_ovld[c] == eo, full_rate[c] ? "R9" : "R10", c,
                    32'(stat_ovld[c]), 32'(eo));
                if (e_stb[c])
                    chk(out_smp[c*PW +: PW] == e_smp[c], e_sub[c] ? "R6/R12" : "R7/R12",
                        c, out_smp[c*PW +: PW], e_smp[c]);
            end
        end
    end

    // One frame of stimulus; en_noise toggles the enables away from the boundary.
    task automatic run_frame(input logic [NCH-1:0] en, input logic [NCH-1:0] noise,
                             input logic [NCH-1:0] fr, input logic [NCH-1:0] tk,
                             input int tk_off, input bit cw, input logic [NCH-1:0] cv,
                             input int cw_off, input string tag);
        for (int cy = 0; cy < FLEN; cy++) begin
            @(posedge clk); #3;
            cur_tag     = tag;
            frame_start = (cy == 0);
            icpt_en     = (cy == 0) ? en : (en ^ noise);
            full_rate   = fr;
            rate_tick   = (cy == tk_off) ? tk : '0;
            ctl_stb     = cw && (cy == cw_off);
            ctl_vld     = cv;
            for (int c = 0; c < NCH; c++) begin
                nat_smp[c*PW +: PW] = {8'(frame_ctr), 4'(c), 4'h2, 8'(frame_ctr), 4'(c), 4'h1};
                ctl_smp[c*PW +: PW] = {8'(frame_ctr) ^ 8'hC3, 4'(c), 4'h4,
                                       8'(cy) ^ 8'h5A, 4'(c), 4'h3};
            end
        end
        frame_ctr++;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state at the ports
        chk(out_stb == '0, "R1", 0, 32'(out_stb), 32'h0);
        chk(out_sub == '0, "R1", 0, 32'(out_sub), 32'h0);
        chk(stat_req == '0, "R1", 0, 32'(stat_req), 32'h0);
        chk(stat_ovld == '0, "R1", 0, 32'(stat_ovld), 32'h0);
        chk(out_smp == '0, "R1", 0, out_smp[31:0], 32'h0);
        @(posedge clk); #3; rst_n = 1'b1;
        // R3: monitor only, host flags ignored
        for (int k = 0; k < 3; k++) run_frame(5'h00, 5'h00, 5'h00, 5'h1F, 5, 1, 5'h1F, 9, "R3");
        // R2: enables switched on at a boundary, noise in between ignored
        run_frame(5'h1F, 5'h0A, 5'h00, 5'h1F, 4, 1, 5'h1F, 8, "R2");
        run_frame(5'h1F, 5'h15, 5'h00, 5'h1F, 7, 1, 5'h15, 3, "R2");
        run_frame(5'h1F, 5'h1F, 5'h00, 5'h1F, 2, 1, 5'h0E, 12, "R6");
        run_frame(5'h1F, 5'h00, 5'h00, 5'h1F, 9, 0, 5'h1F, 1, "R7");
        run_frame(5'h1F, 5'h00, 5'h00, 5'h00, 3, 1, 5'h1F, 6, "R6");
        run_frame(5'h0C, 5'h00, 5'h00, 5'h00, 3, 1, 5'h1F, 6, "R2");
        // R8: tick under disabled intercept, enabled when judged
        run_frame(5'h00, 5'h00, 5'h00, 5'h1F, 6, 0, 5'h00, 0, "R8");
        run_frame(5'h1F, 5'h00, 5'h00, 5'h00, 6, 1, 5'h1F, 4, "R8");
        run_frame(5'h1F, 5'h00, 5'h00, 5'h00, 6, 1, 5'h1F, 4, "R8");
        // R11: ticks and control words on the boundary cycle
        run_frame(5'h1F, 5'h00, 5'h00, 5'h1F, 0, 1, 5'h1F, 0, "R11");
        run_frame(5'h1F, 5'h00, 5'h00, 5'h1F, 0, 1, 5'h0F, 0, "R11");
        run_frame(5'h1F, 5'h00, 5'h00, 5'h1F, 0, 1, 5'h1B, 0, "R11");
        run_frame(5'h1F, 5'h00, 5'h00, 5'h00, 1, 1, 5'h17, 15, "R11");
        // R9: frame-rate streams
        for (int k = 0; k < 4; k++) run_frame(5'h12, 5'h00, 5'h12, 5'h12, 5, 1, 5'h12, 7, "R9");
        // R12 and mixed patterns
        for (int k = 0; k < 40; k++)
            run_frame(5'($urandom), 5'($urandom), 5'($urandom), 5'($urandom),
                      int'($urandom % FLEN), 1'($urandom), 5'($urandom),
                      int'($urandom % FLEN), "R12");
        for (int k = 0; k < 4; k++) run_frame(5'h00, 5'h00, 5'h00, 5'h00, 0, 0, 5'h00, 0, "drain");
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog [%s]: actual hung expected finished", cur_tag);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule